// File: doc/BRIEF.md
# Trimmed Clock-Out Divider

This block divides a reference square wave of nominally 32,768 Hz into a clock-out pin and into the ticks that drive a calendar. The ticks are a 1 Hz pulse and a 100 Hz pulse. Crystal error is corrected digitally. A signed trim value adds or removes single reference counts. These corrections are spread evenly over a fixed correction window, so the long-term rate changes in steps of one part per window length. With the default window of one million reference cycles, that is 1 ppm per step, over a range of ±255 ppm.

The clock-out pin can carry the raw reference or one of three divided rates. The raw reference bypasses the trim. The other three rates come from the trimmed count. A new output selection takes effect only while the old and the new source are both low, so the pin never emits a shortened pulse. When the output enable is low, the pin is held low and the ticks keep running.

The reference input must be synchronous to `clk` and must stay at each level for at least one `clk` cycle. Each rising edge of the reference is one reference count.

Top module: `clkout_trim_div`

## Requirements
- R1: While reset is active and in the first cycle after it, `clk_out`, `tick_1hz` and `tick_100hz` are all 0.
- R2: With a trim magnitude of 0, `tick_1hz` pulses once every 2^REF_LOG2 reference rising edges. The first pulse follows exactly the 2^REF_LOG2-th rising edge after reset.
- R3: `tick_100hz` pulses exactly TICK_HZ (100) times per 2^REF_LOG2 trimmed counts, evenly spread. Its last pulse of each span coincides with `tick_1hz`.
- R4: `trim_mag` is the magnitude and `trim_neg` is the sign (0 = positive). With a constant positive trim, the trimmed count after n reference edges since reset is n + floor(n·trim_mag/WINDOW). Each correction event inserts one extra count.
- R5: With `trim_neg` = 1, the trimmed count after n edges since reset is n − floor(n·trim_mag/WINDOW). Each correction event swallows one count.
- R6: `out_sel` selects the source of `clk_out`: 3 is the reference level, untrimmed and delayed by two `clk` cycles; 2 is the trimmed count divided by 4; 1 is the trimmed count divided by 8; 0 is the 1 Hz square wave (the top bit of the trimmed count).
- R7: A change of `out_sel` takes effect only in a cycle where the current source and the requested source are both low. A high pulse in progress is never cut short, and no new pulse begins at the switch.
- R8: When `out_en` is 0, `clk_out` is 0 from the next cycle on. The ticks continue unaffected.
- R9: `tick_1hz` and `tick_100hz` are single-cycle pulses. They appear only in the cycle after a reference rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Reference square wave, synchronous to clk |
| trim_neg | input | 1 | Trim sign: 1 swallows counts, 0 inserts counts |
| trim_mag | input | MAG_W | Trim magnitude in counts per correction window |
| out_sel | input | 2 | Clock-out source select |
| out_en | input | 1 | Clock-out enable; 0 holds the pin low |
| clk_out | output | 1 | Clock-out pin level |
| tick_100hz | output | 1 | Trimmed 100 Hz calendar tick |
| tick_1hz | output | 1 | Trimmed 1 Hz tick |

## Verification
Several properties are checked on every cycle:
- the correction accumulator stays inside its window;
- an insert advances the count by two and a swallow freezes it;
- ticks appear only after a reference edge;
- a selection change lands only while the pin is low;
- a disabled pin stays low.

The exact tick position under a given trim, the 100-per-second spread, the edge counts of each divided output and the holding of a high level across a select change depend on whole sequences. Only the bench's directed scenarios show those.

// File: rtl/clkout_trim_pkg.sv
package clkout_trim_pkg;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_DIV8 = 2'd1,
        SRC_DIV4 = 2'd2,
        SRC_REF  = 2'd3
    } src_sel_e;

endpackage

// File: rtl/trim_accum.sv
module trim_accum #(
    parameter int WINDOW = 1_000_000,
    parameter int MAG_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic [MAG_W-1:0] mag,
    output logic             adj_ev
);
    localparam int AW = $clog2(WINDOW + (1 << MAG_W));

    typedef struct packed {
        logic [AW-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [AW-1:0] sum;

    always_comb begin
        st_d   = st_q;
        adj_ev = 1'b0;
        sum    = st_q.acc + AW'(mag);
        if (ref_tick) begin
            if (sum >= AW'(WINDOW)) begin
                adj_ev   = 1'b1;
                st_d.acc = sum - AW'(WINDOW);
            end else begin
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: the spreading accumulator never leaves the window
    p_acc_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < AW'(WINDOW));

endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
    parameter int REF_LOG2 = 15,
    parameter int TICK_HZ  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic adj_ev,
    input  logic neg,
    output logic lvl_div4,
    output logic lvl_div8,
    output logic lvl_slow,
    output logic tick_1hz,
    output logic tick_fast
);
    localparam int CW = REF_LOG2;
    localparam int SW = $clog2(2 * TICK_HZ + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] frac;
        logic          t_slow;
        logic          t_fast;
    } tg_st_t;

    tg_st_t st_d, st_q;
    logic [1:0]    inc;
    logic [SW-1:0] step;
    logic [CW:0]   cnt_sum;
    logic [CW:0]   frac_sum;

    always_comb begin
        st_d = st_q;
        if (!ref_tick)   inc = 2'd0;
        else if (!adj_ev) inc = 2'd1;
        else if (neg)    inc = 2'd0;
        else             inc = 2'd2;
        step     = (inc == 2'd2) ? SW'(2 * TICK_HZ) : (inc == 2'd1) ? SW'(TICK_HZ) : '0;
        cnt_sum  = {1'b0, st_q.cnt} + (CW + 1)'(inc);
        frac_sum = {1'b0, st_q.frac} + (CW + 1)'(step);
        st_d.cnt    = cnt_sum[CW-1:0];
        st_d.frac   = frac_sum[CW-1:0];
        st_d.t_slow = cnt_sum[CW];
        st_d.t_fast = frac_sum[CW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_div4  = st_q.cnt[1];
    assign lvl_div8  = st_q.cnt[2];
    assign lvl_slow  = st_q.cnt[CW-1];
    assign tick_1hz  = st_q.t_slow;
    assign tick_fast = st_q.t_fast;

    p_insert_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && adj_ev && !neg) |=> (st_q.cnt == $past(st_q.cnt) + CW'(2)));

    p_swallow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && adj_ev && neg) |=> $stable(st_q.cnt));

    p_slow_after_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.t_slow |-> $past(ref_tick));

    p_fast_after_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.t_fast |-> $past(ref_tick));

endmodule

// File: rtl/clk_sel.sv
module clk_sel
    import clkout_trim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] src,
    input  logic [1:0] sel,
    input  logic       en,
    output logic       out
);
    typedef struct packed {
        src_sel_e act;
        logic     lvl;
    } cs_st_t;

    cs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!src[st_q.act] && !src[sel]) st_d.act = src_sel_e'(sel);
        st_d.lvl = en && src[st_d.act];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{act: SRC_SLOW, lvl: 1'b0};
        else        st_q <= st_d;
    end

    assign out = st_q.lvl;

    // R7: a new source is only ever adopted while the pin is low
    p_switch_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act != $past(st_q.act)) |-> !st_q.lvl);

    p_disable_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !st_q.lvl);

endmodule

// File: rtl/clkout_trim_div.sv
module clkout_trim_div #(
    parameter int REF_LOG2 = 15,
    parameter int WINDOW   = 1_000_000,
    parameter int MAG_W    = 8,
    parameter int TICK_HZ  = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             trim_neg,
    input  logic [MAG_W-1:0] trim_mag,
    input  logic [1:0]       out_sel,
    input  logic             out_en,
    output logic             clk_out,
    output logic             tick_100hz,
    output logic             tick_1hz
);
    logic       ref_d, ref_q;
    logic       ref_rise;
    logic       adj_ev;
    logic       lvl_div4, lvl_div8, lvl_slow;
    logic [3:0] src;

    always_comb begin
        ref_d    = ref_in;
        ref_rise = ref_in && !ref_q;
        src      = {ref_q, lvl_div4, lvl_div8, lvl_slow};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_d;
    end

    trim_accum #(.WINDOW(WINDOW), .MAG_W(MAG_W)) u_trim (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_rise),
        .mag      (trim_mag),
        .adj_ev   (adj_ev)
    );

    tick_gen #(.REF_LOG2(REF_LOG2), .TICK_HZ(TICK_HZ)) u_ticks (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_rise),
        .adj_ev    (adj_ev),
        .neg       (trim_neg),
        .lvl_div4  (lvl_div4),
        .lvl_div8  (lvl_div8),
        .lvl_slow  (lvl_slow),
        .tick_1hz  (tick_1hz),
        .tick_fast (tick_100hz)
    );

    clk_sel u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src),
        .sel   (out_sel),
        .en    (out_en),
        .out   (clk_out)
    );

endmodule

// File: tb/sim_clkout_trim_div.sv
`timescale 1ns/1ps
module sim_clkout_trim_div;
    localparam int LOG2 = 10;
    localparam int WIN  = 1000;
    localparam int SPAN = 1 << LOG2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       trim_neg = 1'b0;
    logic [7:0] trim_mag = 8'd0;
    logic [1:0] out_sel = 2'd3;
    logic       out_en = 1'b1;
    logic       clk_out, tick_100hz, tick_1hz;

    int checks = 0;
    int errors = 0;
    int out_rises = 0;
    int stray = 0;
    bit out_prev = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clkout_trim_div #(.REF_LOG2(LOG2), .WINDOW(WIN), .MAG_W(8), .TICK_HZ(100)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .trim_neg(trim_neg),
        .trim_mag(trim_mag), .out_sel(out_sel), .out_en(out_en),
        .clk_out(clk_out), .tick_100hz(tick_100hz), .tick_1hz(tick_1hz)
    );

    always @(negedge clk) begin
        if (rst_n && clk_out && !out_prev) out_rises++;
        out_prev = clk_out;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n  = 1'b0;
        ref_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one reference period: rise, sample ticks, fall; ticks must be low before the rise
    task automatic ref_cycle(output bit t1, output bit t100);
        @(negedge clk);
        if (tick_1hz || tick_100hz) stray++;
        ref_in = 1'b1;
        @(negedge clk);
        t1   = tick_1hz;
        t100 = tick_100hz;
        ref_in = 1'b0;
    endtask

    function automatic int first_tick(input int mag, input bit neg);
        for (int n = 1; n < 8 * SPAN; n++) begin
            int t;
            t = neg ? n - (n * mag) / WIN : n + (n * mag) / WIN;
            if (t >= SPAN) return n;
        end
        return -1;
    endfunction

    task automatic test_reset;
        rst_n = 1'b0;
        idle(2);
        check(!clk_out && !tick_1hz && !tick_100hz, "R1 outputs in reset",
              {clk_out, tick_1hz, tick_100hz}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!clk_out && !tick_1hz && !tick_100hz, "R1 outputs after reset",
              {clk_out, tick_1hz, tick_100hz}, 0);
    endtask

    task automatic test_untrimmed;
        int first1 = -1;
        int n1 = 0;
        int n100 = 0;
        bit both = 1'b0;
        trim_mag = 8'd0;
        out_sel  = 2'd3;
        out_en   = 1'b1;
        do_reset();
        out_rises = 0;
        for (int n = 1; n <= SPAN; n++) begin
            bit t1, t100;
            ref_cycle(t1, t100);
            if (t1) begin
                n1++;
                if (first1 < 0) first1 = n;
                both = t100;
            end
            if (t100) n100++;
        end
        idle(3);
        check(first1 == SPAN && n1 == 1, "R2 first 1 Hz tick position", first1, SPAN);
        check(n100 == 100, "R3 fast ticks per span", n100, 100);
        check(both, "R3 last fast tick with 1 Hz tick", both, 1);
        check(out_rises == SPAN, "R6 reference bypass edges", out_rises, SPAN);
    endtask

    task automatic test_divided;
        bit t1, t100;
        int hi = 0;
        out_sel = 2'd2;
        idle(2);
        out_rises = 0;
        for (int i = 0; i < 64; i++) ref_cycle(t1, t100);
        idle(3);
        check(out_rises == 16, "R6 divide-by-4 edges", out_rises, 16);
        out_sel = 2'd1;
        idle(2);
        out_rises = 0;
        for (int i = 0; i < 64; i++) ref_cycle(t1, t100);
        idle(3);
        check(out_rises == 8, "R6 divide-by-8 edges", out_rises, 8);
        out_sel = 2'd0;
        idle(2);
        out_rises = 0;
        for (int i = 0; i < 64; i++) begin
            ref_cycle(t1, t100);
            if (clk_out) hi++;
        end
        check(out_rises == 0 && hi == 0, "R6 slow source low in first half", out_rises + hi, 0);
    endtask

    task automatic test_disable;
        bit t1, t100;
        int n100 = 0;
        int hi = 0;
        out_sel = 2'd3;
        out_en  = 1'b0;
        idle(2);
        out_rises = 0;
        for (int i = 0; i < SPAN; i++) begin
            ref_cycle(t1, t100);
            if (t100) n100++;
            if (clk_out) hi++;
        end
        check(hi == 0 && out_rises == 0, "R8 pin low while disabled", hi, 0);
        check(n100 == 100, "R8 ticks continue while disabled", n100, 100);
        out_en = 1'b1;
    endtask

    task automatic test_trim(input int mag, input bit neg, input string req);
        int got = -1;
        int exp;
        exp      = first_tick(mag, neg);
        trim_mag = 8'(mag);
        trim_neg = neg;
        do_reset();
        for (int n = 1; n <= 4 * SPAN && got < 0; n++) begin
            bit t1, t100;
            ref_cycle(t1, t100);
            if (t1) got = n;
        end
        check(got == exp, req, got, exp);
        trim_mag = 8'd0;
        trim_neg = 1'b0;
    endtask

    task automatic test_switch;
        out_sel = 2'd3;
        out_en  = 1'b1;
        do_reset();
        idle(3);
        ref_in = 1'b1;
        idle(3);
        check(clk_out == 1'b1, "R6 reference level selected", clk_out, 1);
        out_sel = 2'd0;
        idle(4);
        check(clk_out == 1'b1, "R7 high pulse held across select change", clk_out, 1);
        ref_in = 1'b0;
        idle(3);
        check(clk_out == 1'b0, "R7 pin low after old pulse ends", clk_out, 0);
        out_rises = 0;
        ref_in = 1'b1;
        idle(3);
        ref_in = 1'b0;
        idle(2);
        check(out_rises == 0, "R7 new source in force after switch", out_rises, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        errors++;
        report();
    end

    initial begin
        test_reset();
        test_untrimmed();
        test_divided();
        test_disable();
        test_trim(255, 1'b0, "R4 positive trim inserts counts");
        test_trim(40, 1'b0, "R4 small positive trim");
        test_trim(255, 1'b1, "R5 negative trim swallows counts");
        test_trim(7, 1'b1, "R5 small negative trim");
        test_switch();
        check(stray == 0, "R9 ticks only after a reference edge", stray, 0);
        report();
    end
endmodule